// File: doc/BRIEF.md
# Memory channel serial-mode packet scheduler

This block decides when serial-mode control packets go out to the memory devices on a channel. Each packet carries a power hint that tells the devices either to fall back to standby or to stay active. The cadence follows a two-bit operating mode held in a small register: one packet ahead of every transaction, one packet every fourth bus cycle, a continuous stream, or nothing at all. In the continuous mode, a long enough run of packets puts the devices into reset. The block reports that condition on a dedicated output.

The same register holds two enables for automatic clock halting, one for the receive side and one for the transmit side. When an enable is set, the matching clock gate closes once that direction has been idle for a short while. It opens again as soon as a transaction in that direction is announced. The access engine raises a start strobe with a direction bit. The block releases the transaction on its own issue strobe. In the per-transaction mode that release is one cycle late, so the packet always leads the transaction.

A free-running phase counter marks 4-cycle boundaries. A newly programmed mode only becomes active at such a boundary. This keeps the periodic cadence intact across a mode change.

Top module: `smode_pkt_sched`

## Requirements
- R1: The mode register sits at word address 0 and reads back as {28 zeros, rx-halt enable (bit 3), tx-halt enable (bit 2), mode (bits 1:0)}. Its reset value is 0xE (both halt enables set, mode 2'b10). A write updates only bits 3:0. Any other address reads 0, and writes to other addresses change nothing.
- R2: In mode 2'b10, a start strobe produces a packet in the same cycle with the standby hint high. The issue strobe for that transaction follows one cycle later.
- R3: In mode 2'b01, a packet goes out exactly in the cycles whose phase (cycles since reset release, mod 4) is 0, with the standby hint low. A start strobe is issued in its own cycle.
- R4: In mode 2'b00, a packet goes out every cycle with the standby hint low. The device-reset output rises in the cycle after 272 consecutive cycles in that mode and stays high while the mode lasts.
- R5: Leaving mode 2'b00 drops device-reset in the first cycle of the new mode. The 272-cycle count restarts from zero on the next entry.
- R6: Mode 2'b11 emits no packets and never asserts device-reset. A start strobe is issued in its own cycle.
- R7: A written mode becomes active in the first phase-0 cycle that follows a phase-3 cycle after the write. Until then the previous mode keeps running.
- R8: With its halt enable set, a direction's clock gate is low after reset. It is high in the cycle of a start strobe for that direction (read = receive, write = transmit) and in the issue cycle, stays high for 2 further cycles, and is low after that.
- R9: With its halt enable cleared, a direction's clock gate stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access valid |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, same cycle as the access |
| txn_start_i | input | 1 | Transaction-start strobe from the access engine |
| txn_rd_i | input | 1 | Direction of the starting transaction, 1 = read |
| txn_go_o | output | 1 | Transaction issue strobe |
| pkt_send_o | output | 1 | Serial-mode packet sent this cycle |
| pkt_standby_o | output | 1 | Packet hint: 1 = standby after transaction, 0 = stay active |
| dev_reset_o | output | 1 | Devices are being held in reset by the continuous stream |
| rx_clk_en_o | output | 1 | Receive clock gate enable |
| tx_clk_en_o | output | 1 | Transmit clock gate enable |

## Verification
The hardest situation to reach from the ports is the exact edge of the 272-cycle reset threshold. It must be hit twice: once on the first entry into continuous mode, and again after the mode is left and re-entered, to show that the count restarted. The stimulus keeps its own count of cycles since reset, so every mode write can be placed relative to the 4-cycle boundary. Each entry cycle is therefore known. The bench then steps exactly 271 cycles and checks that device-reset is still low, and one more cycle to check that it has risen. The same alignment lets the bench write a new mode in the middle of a period and observe the old cadence still running in the remaining cycles.

// File: rtl/smode_pkg.sv
package smode_pkg;

  typedef enum logic [1:0] {
    MODE_CONT    = 2'b00,
    MODE_ACTIVE  = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_IDLE    = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic     halt_rx;
    logic     halt_tx;
    op_mode_e mode;
  } mode_reg_t;

  localparam mode_reg_t MODE_RESET_VAL = '{halt_rx: 1'b1, halt_tx: 1'b1, mode: MODE_STANDBY};

  // packet due this cycle for the active mode
  function automatic logic pkt_due(input op_mode_e m, input logic phase_zero, input logic start);
    case (m)
      MODE_CONT:    pkt_due = 1'b1;
      MODE_ACTIVE:  pkt_due = phase_zero;
      MODE_STANDBY: pkt_due = start;
      default:      pkt_due = 1'b0;
    endcase
  endfunction

  // continuous-stream run length has reached the reset threshold
  function automatic logic count_reached(input logic [31:0] cnt, input logic [31:0] limit);
    count_reached = (cnt >= limit);
  endfunction

  // clock gate open condition for one direction
  function automatic logic gate_needed(input logic halt_en, input logic recent,
                                       input logic wake, input logic issue);
    gate_needed = !halt_en || recent || wake || issue;
  endfunction

endpackage

// File: rtl/smode_regs.sv
module smode_regs
  import smode_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output mode_reg_t         mode_q
);

  localparam int FIELD_W = $bits(mode_reg_t);
  localparam int PAD_W   = DATA_W - FIELD_W;
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;

  logic hit;
  logic wr_hit;
  logic unused_wdata;

  assign hit          = reg_en && (reg_addr == MODE_ADDR);
  assign wr_hit       = hit && reg_we;
  assign unused_wdata = ^reg_wdata[DATA_W-1:FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET_VAL;
    end else if (wr_hit) begin
      mode_q <= mode_reg_t'(reg_wdata[FIELD_W-1:0]);
    end
  end

  always_comb begin
    if (hit && !reg_we) reg_rdata = {{PAD_W{1'b0}}, mode_q};
    else                reg_rdata = '0;
  end

endmodule

// File: rtl/smode_cadence.sv
module smode_cadence
  import smode_pkg::*;
#(
  parameter int PERIOD       = 4,
  parameter int RESET_CYCLES = 272
) (
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e prog_mode,
  input  logic     txn_start_i,
  input  logic     txn_rd_i,
  output op_mode_e act_mode,
  output logic     phase_zero,
  output logic     pkt_send,
  output logic     pkt_standby,
  output logic     dev_reset,
  output logic     issue,
  output logic     issue_rd
);

  localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] RUN_LIMIT = CNT_W'(RESET_CYCLES);

  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] run_q;
  op_mode_e         act_q;
  logic             held_q;
  logic             held_rd_q;
  logic             phase_last;
  logic             in_standby;
  logic             in_cont;

  assign phase_zero = (ph_q == '0);
  assign phase_last = (ph_q == PH_LAST);
  assign in_standby = (act_q == MODE_STANDBY);
  assign in_cont    = (act_q == MODE_CONT);
  assign act_mode   = act_q;

  // phase counter and boundary-aligned mode switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      act_q <= MODE_RESET_VAL.mode;
    end else begin
      ph_q <= phase_last ? '0 : ph_q + 1'b1;
      if (phase_last) act_q <= prog_mode;
    end
  end

  // saturating run-length count of the continuous stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!in_cont) begin
      run_q <= '0;
    end else if (run_q != RUN_LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  // one-cycle hold-off of the start strobe in per-transaction mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      held_rd_q <= 1'b0;
    end else begin
      held_q    <= in_standby && txn_start_i;
      held_rd_q <= txn_rd_i;
    end
  end

  assign pkt_send    = pkt_due(act_q, phase_zero, txn_start_i);
  assign pkt_standby = pkt_send && in_standby;
  assign dev_reset   = in_cont && count_reached(32'(run_q), 32'(RESET_CYCLES));
  assign issue       = held_q || (!in_standby && txn_start_i);
  assign issue_rd    = held_q ? held_rd_q : txn_rd_i;

endmodule

// File: rtl/smode_gate.sv
module smode_gate
  import smode_pkg::*;
#(
  parameter int IDLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_en,
  input  logic wake,
  input  logic issue,
  output logic gate_en
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CLIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] idle_q;
  logic          recent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= CLIMIT;
    end else if (issue) begin
      idle_q <= '0;
    end else if (idle_q != CLIMIT) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign recent  = (idle_q != CLIMIT);
  assign gate_en = gate_needed(halt_en, recent, wake, issue);

endmodule

// File: rtl/smode_pkt_sched.sv
module smode_pkt_sched
  import smode_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int PERIOD       = 4,
  parameter int RESET_CYCLES = 272,
  parameter int IDLE_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              txn_start_i,
  input  logic              txn_rd_i,
  output logic              txn_go_o,
  output logic              pkt_send_o,
  output logic              pkt_standby_o,
  output logic              dev_reset_o,
  output logic              rx_clk_en_o,
  output logic              tx_clk_en_o
);

  localparam int NDIR = 2;  // index 0 = receive, 1 = transmit

  mode_reg_t       mode_w;
  op_mode_e        act_mode_w;
  logic            phase_zero_w;
  logic            issue_w;
  logic            issue_rd_w;
  logic [NDIR-1:0] halt_w;
  logic [NDIR-1:0] wake_w;
  logic [NDIR-1:0] dir_issue_w;
  logic [NDIR-1:0] gate_w;
  logic            issue_rx_w;
  logic            issue_tx_w;

  smode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mode_q    (mode_w)
  );

  smode_cadence #(.PERIOD(PERIOD), .RESET_CYCLES(RESET_CYCLES)) u_cadence (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode   (mode_w.mode),
    .txn_start_i (txn_start_i),
    .txn_rd_i    (txn_rd_i),
    .act_mode    (act_mode_w),
    .phase_zero  (phase_zero_w),
    .pkt_send    (pkt_send_o),
    .pkt_standby (pkt_standby_o),
    .dev_reset   (dev_reset_o),
    .issue       (issue_w),
    .issue_rd    (issue_rd_w)
  );

  assign halt_w      = {mode_w.halt_tx, mode_w.halt_rx};
  assign wake_w      = {txn_start_i && !txn_rd_i, txn_start_i && txn_rd_i};
  assign dir_issue_w = {issue_w && !issue_rd_w, issue_w && issue_rd_w};
  assign issue_rx_w  = dir_issue_w[0];
  assign issue_tx_w  = dir_issue_w[1];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    smode_gate #(.IDLE_CYCLES(IDLE_CYCLES)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt_en (halt_w[d]),
      .wake    (wake_w[d]),
      .issue   (dir_issue_w[d]),
      .gate_en (gate_w[d])
    );
  end

  assign txn_go_o    = issue_w;
  assign rx_clk_en_o = gate_w[0];
  assign tx_clk_en_o = gate_w[1];

endmodule

// File: rtl/smode_pkt_sched_chk.sv
module smode_pkt_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] act_mode,
  input logic       phase_zero,
  input logic       pkt_send_o,
  input logic       pkt_standby_o,
  input logic       txn_go_o,
  input logic       dev_reset_o,
  input logic       rx_clk_en_o,
  input logic       tx_clk_en_o,
  input logic       issue_rx,
  input logic       issue_tx
);

  // R2: a per-transaction packet is followed by the issue strobe
  p_go_after_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b10 && pkt_send_o) |=> txn_go_o);

  // R2: the standby hint only accompanies a packet
  p_hint_with_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_standby_o |-> pkt_send_o);

  // R3: periodic packets never come in adjacent cycles
  p_active_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b01 && pkt_send_o) |=> !pkt_send_o);

  // R3: periodic packets sit on phase 0
  p_active_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b01 && pkt_send_o) |-> phase_zero);

  // R4: device reset only during the continuous stream
  p_reset_in_cont_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |-> (act_mode == 2'b00 && pkt_send_o));

  // R5: device reset persists until the mode changes
  p_reset_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |=> (dev_reset_o || act_mode != 2'b00));

  // R6: the idle mode is silent
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'b11) |-> (!pkt_send_o && !dev_reset_o));

  // R7: the active mode only moves at a boundary
  p_mode_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_zero |-> $stable(act_mode));

  // R8: a gate is open whenever its direction issues
  p_rx_gate_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rx |-> rx_clk_en_o);

  p_tx_gate_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_tx |-> tx_clk_en_o);

endmodule

bind smode_pkt_sched smode_pkt_sched_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .act_mode      (act_mode_w),
  .phase_zero    (phase_zero_w),
  .pkt_send_o    (pkt_send_o),
  .pkt_standby_o (pkt_standby_o),
  .txn_go_o      (txn_go_o),
  .dev_reset_o   (dev_reset_o),
  .rx_clk_en_o   (rx_clk_en_o),
  .tx_clk_en_o   (tx_clk_en_o),
  .issue_rx      (issue_rx_w),
  .issue_tx      (issue_tx_w)
);

// File: tb/smode_pkt_sched_tb_top.sv
`timescale 1ns/1ps
module smode_pkt_sched_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txn_start = 1'b0;
  logic        txn_rd = 1'b0;
  logic        txn_go, pkt_send, pkt_standby, dev_reset, rx_en, tx_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // {start, expected packet, expected issue} per cycle in mode 2'b10
  localparam logic [2:0] VEC [8] = '{3'b110, 3'b001, 3'b000, 3'b110,
                                     3'b111, 3'b001, 3'b000, 3'b000};

  always #4 clk = ~clk;

  smode_pkt_sched dut_i (
    .clk (clk), .rst_n (rst_n),
    .reg_en (reg_en), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .txn_start_i (txn_start), .txn_rd_i (txn_rd), .txn_go_o (txn_go),
    .pkt_send_o (pkt_send), .pkt_standby_o (pkt_standby),
    .dev_reset_o (dev_reset), .rx_clk_en_o (rx_en), .tx_clk_en_o (tx_en)
  );

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #2 chk(tag, reg_rdata, exp);
    step();
    reg_en = 1'b0;
  endtask

  // move to the first cycle where a freshly written mode is active
  task automatic to_boundary();
    while (cyc % 4 != 3) step();
    step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    bit ok;
    // ---- reset state (R1, R8)
    repeat (3) @(posedge clk);
    reg_en = 1'b1; reg_addr = 4'd0;
    #2;
    chk("R1 reset readback", reg_rdata, 32'hE);
    chk("R2 no packet in reset", {31'b0, pkt_send}, 0);
    chk("R4 no device reset in reset", {31'b0, dev_reset}, 0);
    chk("R8 rx gate low after reset", {31'b0, rx_en}, 0);
    chk("R8 tx gate low after reset", {31'b0, tx_en}, 0);
    @(posedge clk); #1;
    reg_en = 1'b0; rst_n = 1'b1; cyc = 0;

    // ---- table walk in the reset mode 2'b10 (R2)
    for (int i = 0; i < 8; i++) begin
      txn_start = VEC[i][2]; txn_rd = 1'b1;
      #2;
      chk($sformatf("R2 packet vec %0d", i), {31'b0, pkt_send}, {31'b0, VEC[i][1]});
      chk($sformatf("R2 issue vec %0d", i), {31'b0, txn_go}, {31'b0, VEC[i][0]});
      chk($sformatf("R2 standby hint vec %0d", i), {31'b0, pkt_standby}, {31'b0, VEC[i][1]});
      step();
    end
    txn_start = 1'b0;
    repeat (2) step();
    #2;
    chk("R8 rx gate closed after idle", {31'b0, rx_en}, 0);
    chk("R8 tx gate never opened", {31'b0, tx_en}, 0);

    // ---- transmit gate wake, issue, linger (R8)
    step();
    txn_start = 1'b1; txn_rd = 1'b0;
    #2 chk("R8 tx gate opens on start", {31'b0, tx_en}, 1);
    chk("R8 rx gate stays closed", {31'b0, rx_en}, 0);
    step(); txn_start = 1'b0;
    #2 chk("R8 tx gate open at issue", {31'b0, tx_en & txn_go}, 1);
    step();
    #2 chk("R8 tx gate idle 1", {31'b0, tx_en}, 1);
    step();
    #2 chk("R8 tx gate idle 2", {31'b0, tx_en}, 1);
    step();
    #2 chk("R8 tx gate closes", {31'b0, tx_en}, 0);
    step();

    // ---- halt enables cleared (R9)
    wr(4'd0, 32'h2);
    #2 chk("R9 rx gate forced open", {31'b0, rx_en}, 1);
    chk("R9 tx gate forced open", {31'b0, tx_en}, 1);
    step();
    rd_chk(4'd0, 32'h2, "R1 readback after write");

    // ---- periodic mode 2'b01 (R3)
    wr(4'd0, 32'h1);
    to_boundary();
    for (int k = 0; k < 8; k++) begin
      txn_start = (k == 2);
      #2;
      chk($sformatf("R3 packet phase %0d", k), {31'b0, pkt_send}, {31'b0, (k % 4 == 0)});
      chk($sformatf("R3 active hint %0d", k), {31'b0, pkt_standby}, 0);
      if (k == 2) chk("R3 issue same cycle", {31'b0, txn_go}, 1);
      step();
    end
    txn_start = 1'b0;
    #2 chk("R3 packet at phase 0", {31'b0, pkt_send}, 1);
    step();
    // write mode 2'b00 in a phase-1 cycle (R7)
    wr(4'd0, 32'h0);
    #2 chk("R7 old mode still active phase 2", {31'b0, pkt_send}, 0);
    step();
    #2 chk("R7 old mode still active phase 3", {31'b0, pkt_send}, 0);
    step();
    #2 chk("R4 continuous starts at boundary", {31'b0, pkt_send}, 1);
    chk("R4 no reset at entry", {31'b0, dev_reset}, 0);

    // ---- 272-cycle threshold (R4)
    ok = 1'b1;
    for (int k = 1; k <= 271; k++) begin
      step(); #2;
      if (!pkt_send || pkt_standby || dev_reset) ok = 1'b0;
    end
    chk("R4 stream without reset for 271 cycles", {31'b0, ok}, 1);
    step();
    #2 chk("R4 reset after 272 cycles", {31'b0, dev_reset}, 1);
    repeat (3) step();
    #2 chk("R4 reset sticky", {31'b0, dev_reset}, 1);

    // ---- leaving and re-entering (R5)
    wr(4'd0, 32'h2);
    to_boundary();
    #2 chk("R5 reset drops on leaving", {31'b0, dev_reset}, 0);
    chk("R5 no packet without start", {31'b0, pkt_send}, 0);
    wr(4'd0, 32'h0);
    to_boundary();
    ok = 1'b1;
    for (int k = 1; k <= 271; k++) begin
      step(); #2;
      if (dev_reset) ok = 1'b0;
    end
    chk("R5 count restarted on re-entry", {31'b0, ok}, 1);
    step();
    #2 chk("R5 reset after full second run", {31'b0, dev_reset}, 1);

    // ---- idle mode 2'b11 (R6)
    wr(4'd0, 32'h3);
    to_boundary();
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      txn_start = (k == 5);
      #2;
      if (pkt_send || dev_reset) ok = 1'b0;
      if (k == 5) chk("R6 issue same cycle", {31'b0, txn_go}, 1);
      step();
    end
    txn_start = 1'b0;
    chk("R6 silent in idle mode", {31'b0, ok}, 1);

    // ---- address decode and field width (R1)
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk(4'd0, 32'h3, "R1 other address write ignored");
    rd_chk(4'd1, 32'h0, "R1 other address reads zero");
    wr(4'd0, 32'hFFFF_FFF5);
    rd_chk(4'd0, 32'h5, "R1 upper write bits dropped");

    done = 1'b1;
    finish_run();
  end

endmodule